// File: doc/BRIEF.md
# Mode Register Command Decoder

This block sits on the device side of a double-data-rate memory and samples the command pins at every rising clock. When clock enable is high and chip select, row strobe, column strobe and write enable are all low, the cycle is a mode-setting command. Bank address bit 0 then selects one of two targets. The main register holds burst length, burst ordering and read latency, and can request a DLL reset. The extended register holds the DLL enable and the output driver strength. The stored, decoded fields go to a burst counter and a read-latency pipeline elsewhere in the device.

Each write is checked before it is stored. A reserved code, or a reserved bit that is not zero, leaves the target register as it was and sets a sticky configuration-error flag. A mode command is legal only when all banks are precharged. An accepted command opens a settling window, and any command inside that window is a sequencing violation. A mode command that breaks either rule is dropped and sets a sticky violation flag.

Top module: `mode_reg_decoder`

## Requirements
- R1: A mode command is cke_i=1 with cs_ni, ras_ni, cas_ni and we_ni all 0 at a rising clock. A cycle with cke_i=0, or with any strobe high, changes no stored field.
- R2: With ba_i[0]=0 the main register is written. addr_i[2:0] gives the burst length (001→2, 010→4, 011→8). addr_i[3] gives the burst ordering (0 sequential, 1 interleaved). addr_i[6:4] gives the read latency (011→3, 100→4, 101→5). The outputs show the new values in the cycle after the command edge.
- R3: A main-register write is rejected when the burst-length or latency code is reserved, when addr_i[7] (test mode) is 1, when addr_i[11:9] is nonzero, or when ba_i[1] is 1. A rejected write leaves the main fields unchanged and sets cfg_err_o, which stays high until reset.
- R4: An accepted main-register write with addr_i[8]=1 drives dll_reset_o high for exactly the one following cycle. It also stores the other fields.
- R5: With ba_i[0]=1 the extended register is written. addr_i[0]=0 sets dll_en_o=1 and addr_i[0]=1 clears it. {addr_i[6],addr_i[1]} gives the driver strength (00 full, 01 weak, 10 matched) on drive_str_o.
- R6: An extended-register write is rejected when {addr_i[6],addr_i[1]}=11, when any of addr_i[5:2] or addr_i[11:7] is 1, or when ba_i[1] is 1. A rejected write leaves the extended fields unchanged and sets cfg_err_o.
- R7: A mode command while banks_idle_i=0 sets seq_viol_o, which stays high until reset. It changes no field, does not set cfg_err_o and opens no settling window.
- R8: After a mode command issued with banks idle and outside the window, busy_o is high for MRD_CYCLES-1 cycles (1 by default). Any command inside that window (cke_i=1, cs_ni=0, strobes not all high) sets seq_viol_o, and a mode command inside the window is ignored.
- R9: After reset: burst length 2, sequential ordering, latency 3, DLL disabled, driver strength 00, and dll_reset_o, busy_o, cfg_err_o and seq_viol_o all 0.
- R10: A main-register write leaves the extended fields unchanged, and an extended-register write leaves the main fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; pins sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address; bit 0 selects the register |
| addr_i | input | ADDR_W | Address pins carrying the register value |
| banks_idle_i | input | 1 | High when every bank is precharged |
| burst_len_o | output | 4 | Burst length in beats (2, 4, 8) |
| burst_ilv_o | output | 1 | 1 = interleaved ordering |
| read_lat_o | output | 3 | Read latency in clocks |
| dll_reset_o | output | 1 | One-cycle DLL reset request |
| dll_en_o | output | 1 | DLL enable |
| drive_str_o | output | 2 | Driver strength code |
| busy_o | output | 1 | Settling window is open |
| cfg_err_o | output | 1 | Sticky reserved-setting flag |
| seq_viol_o | output | 1 | Sticky sequencing-violation flag |

## Verification
Properties checked on every cycle: the settling window opens after a timing-legal command, the stored fields hold while the window is open, while banks are busy or while clock enable is low, both flags stay set once raised, the DLL reset pulse lasts one cycle, and the burst length is always 2, 4 or 8. Only the bench scenarios can show that each field decodes to the right value. These are a sweep of every burst, ordering and latency code, every driver and DLL combination, and one reserved bit at a time. The scenarios also show that rejected writes leave the old values in place and that a main write does not disturb the extended fields.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef struct packed {
    logic [3:0] blen;
    logic       ilv;
    logic [2:0] lat;
  } main_cfg_t;

  typedef struct packed {
    logic       dll_en;
    logic [1:0] drv;
  } ext_cfg_t;

  localparam main_cfg_t MAIN_RST = '{blen: 4'd2, ilv: 1'b0, lat: 3'd3};
  localparam ext_cfg_t  EXT_RST  = '{dll_en: 1'b0, drv: 2'b00};

  // bit positions that neighbours rely on
  localparam int unsigned BIT_ORDER  = 3;
  localparam int unsigned BIT_DLLRST = 8;
  localparam int unsigned BIT_DLLOFF = 0;
  localparam int unsigned BIT_DRV_LO = 1;
  localparam int unsigned BIT_DRV_HI = 6;
endpackage

// File: rtl/mrd_cmd_detect.sv
module mrd_cmd_detect (
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output logic is_cmd_o,
  output logic is_mode_o
);
  logic sel;
  assign sel       = cke_i & ~cs_ni;
  assign is_cmd_o  = sel & ~(ras_ni & cas_ni & we_ni);
  assign is_mode_o = sel & ~ras_ni & ~cas_ni & ~we_ni;
endmodule

// File: rtl/mrd_field_check.sv
module mrd_field_check
  import mrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              ba_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              main_ok_o,
  output logic              ext_ok_o,
  output logic              dll_rst_req_o,
  output main_cfg_t         main_cfg_o,
  output ext_cfg_t          ext_cfg_o
);
  // bits 0-6 and 8 carry main fields; 0, 1, 6 carry extended fields
  localparam logic [ADDR_W-1:0] MAIN_USED = ADDR_W'(12'h17F);
  localparam logic [ADDR_W-1:0] EXT_USED  = ADDR_W'(12'h043);

  logic blen_ok, lat_ok, drv_ok;

  always_comb begin
    blen_ok         = 1'b1;
    main_cfg_o.blen = 4'd2;
    unique case (addr_i[2:0])
      3'b001:  main_cfg_o.blen = 4'd2;
      3'b010:  main_cfg_o.blen = 4'd4;
      3'b011:  main_cfg_o.blen = 4'd8;
      default: blen_ok = 1'b0;
    endcase
    lat_ok         = 1'b1;
    main_cfg_o.lat = 3'd3;
    unique case (addr_i[6:4])
      3'b011:  main_cfg_o.lat = 3'd3;
      3'b100:  main_cfg_o.lat = 3'd4;
      3'b101:  main_cfg_o.lat = 3'd5;
      default: lat_ok = 1'b0;
    endcase
    main_cfg_o.ilv = addr_i[BIT_ORDER];
  end

  assign drv_ok           = ~(addr_i[BIT_DRV_HI] & addr_i[BIT_DRV_LO]);
  assign ext_cfg_o.dll_en = ~addr_i[BIT_DLLOFF];
  assign ext_cfg_o.drv    = {addr_i[BIT_DRV_HI], addr_i[BIT_DRV_LO]};
  assign dll_rst_req_o    = addr_i[BIT_DLLRST];

  assign main_ok_o = blen_ok & lat_ok & ~|(addr_i & ~MAIN_USED) & ~ba_hi_i;
  assign ext_ok_o  = drv_ok & ~|(addr_i & ~EXT_USED) & ~ba_hi_i;
endmodule

// File: rtl/mrd_lockout.sv
module mrd_lockout #(
  parameter int unsigned MRD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = (MRD_CYCLES > 2) ? $clog2(MRD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(MRD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_WINDOW_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R8
  AST_WINDOW_STAYS_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o); // R8
endmodule

// File: rtl/mode_reg_decoder.sv
module mode_reg_decoder
  import mrd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned MRD_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  output logic [3:0]        burst_len_o,
  output logic              burst_ilv_o,
  output logic [2:0]        read_lat_o,
  output logic              dll_reset_o,
  output logic              dll_en_o,
  output logic [1:0]        drive_str_o,
  output logic              busy_o,
  output logic              cfg_err_o,
  output logic              seq_viol_o
);
  logic      is_cmd, is_mode, main_ok, ext_ok, dll_req;
  logic      timing_ok, accept_main, accept_ext, bad_value, viol_now;
  main_cfg_t main_new, main_q;
  ext_cfg_t  ext_new, ext_q;
  logic      err_q, viol_q, dll_rst_q;

  mrd_cmd_detect u_detect (
    .cke_i    (cke_i),
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .is_cmd_o (is_cmd),
    .is_mode_o(is_mode)
  );

  mrd_field_check #(.ADDR_W(ADDR_W)) u_check (
    .ba_hi_i      (ba_i[1]),
    .addr_i       (addr_i),
    .main_ok_o    (main_ok),
    .ext_ok_o     (ext_ok),
    .dll_rst_req_o(dll_req),
    .main_cfg_o   (main_new),
    .ext_cfg_o    (ext_new)
  );

  mrd_lockout #(.MRD_CYCLES(MRD_CYCLES)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(timing_ok),
    .busy_o (busy_o)
  );

  assign timing_ok   = is_mode & ~busy_o & banks_idle_i;
  assign accept_main = timing_ok & ~ba_i[0] & main_ok;
  assign accept_ext  = timing_ok & ba_i[0] & ext_ok;
  assign bad_value   = timing_ok & (ba_i[0] ? ~ext_ok : ~main_ok);
  assign viol_now    = (is_cmd & busy_o) | (is_mode & ~banks_idle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q    <= MAIN_RST;
      ext_q     <= EXT_RST;
      err_q     <= 1'b0;
      viol_q    <= 1'b0;
      dll_rst_q <= 1'b0;
    end else begin
      if (accept_main) main_q <= main_new;
      if (accept_ext)  ext_q  <= ext_new;
      err_q     <= err_q | bad_value;
      viol_q    <= viol_q | viol_now;
      dll_rst_q <= accept_main & dll_req;
    end
  end

  assign burst_len_o = main_q.blen;
  assign burst_ilv_o = main_q.ilv;
  assign read_lat_o  = main_q.lat;
  assign dll_en_o    = ext_q.dll_en;
  assign drive_str_o = ext_q.drv;
  assign dll_reset_o = dll_rst_q;
  assign cfg_err_o   = err_q;
  assign seq_viol_o  = viol_q;

  AST_CKE_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(main_q) && $stable(ext_q))); // R1
  AST_BLEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(burst_len_o) && !burst_len_o[0]); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R3
  AST_DLL_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |=> !dll_reset_o); // R4
  AST_BANKS_OPEN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !banks_idle_i |=> ($stable(main_q) && $stable(ext_q))); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_viol_o |=> seq_viol_o); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(main_q) && $stable(ext_q))); // R8
endmodule

// File: tb/sim_mode_reg_decoder.sv
`timescale 1ns/1ps
module sim_mode_reg_decoder;
  localparam int TB_MRD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic idle = 1'b1;
  logic [3:0] blen; logic ilv; logic [2:0] lat;
  logic dll_rst, dll_en, busy, err, viol; logic [1:0] drv;

  int n_chk = 0, n_fail = 0;

  // expected model
  int e_bl, e_cl, e_busy; bit e_bt, e_dll, e_rst, e_err, e_viol; int e_drv;

  always #2.5 clk = ~clk;

  mode_reg_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .banks_idle_i(idle),
    .burst_len_o(blen), .burst_ilv_o(ilv), .read_lat_o(lat), .dll_reset_o(dll_rst),
    .dll_en_o(dll_en), .drive_str_o(drv), .busy_o(busy), .cfg_err_o(err),
    .seq_viol_o(viol)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "burst_len", int'(blen), e_bl);
    chk(req, "burst_ilv", int'(ilv), int'(e_bt));
    chk(req, "read_lat", int'(lat), e_cl);
    chk(req, "dll_en", int'(dll_en), int'(e_dll));
    chk(req, "drive_str", int'(drv), e_drv);
    chk(req, "dll_reset", int'(dll_rst), int'(e_rst));
    chk(req, "busy", int'(busy), int'(e_busy != 0));
    chk(req, "cfg_err", int'(err), int'(e_err));
    chk(req, "seq_viol", int'(viol), int'(e_viol));
  endtask

  task automatic model_reset();
    e_bl = 2; e_cl = 3; e_bt = 0; e_dll = 0; e_drv = 0;
    e_rst = 0; e_busy = 0; e_err = 0; e_viol = 0;
  endtask

  // R9: reset state
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; idle = 1;
    model_reset();
    @(negedge clk);
    check_all("R9");
    rst_n = 1'b1;
  endtask

  // drive one cycle at a negedge, predict, check at the next negedge
  task automatic apply(input bit k, input bit c, input bit r, input bit a_, input bit w,
                       input logic [1:0] b, input logic [11:0] ad, input bit id,
                       input string req);
    bit is_cmd, is_mode, tok, ok;
    int bc, lc, dc;
    cke = k; cs_n = c; ras_n = r; cas_n = a_; we_n = w; ba = b; addr = ad; idle = id;
    is_cmd  = k && !c && !(r && a_ && w);
    is_mode = k && !c && !r && !a_ && !w;
    tok = is_mode && (e_busy == 0) && id;
    if ((is_cmd && e_busy != 0) || (is_mode && !id)) e_viol = 1;
    e_rst = 0;
    if (tok) begin
      if (!b[0]) begin
        bc = int'(ad[2:0]); lc = int'(ad[6:4]);
        ok = (bc >= 1 && bc <= 3) && (lc >= 3 && lc <= 5) && !ad[7] &&
             (ad[11:9] == 0) && !b[1];
        if (ok) begin
          e_bl = 1 << bc; e_cl = lc; e_bt = ad[3]; e_rst = ad[8];
        end else e_err = 1;
      end else begin
        dc = int'({ad[6], ad[1]});
        ok = (dc != 3) && (ad[5:2] == 0) && (ad[11:7] == 0) && !b[1];
        if (ok) begin
          e_dll = !ad[0]; e_drv = dc;
        end else e_err = 1;
      end
    end
    if (tok) e_busy = TB_MRD - 1;
    else if (e_busy > 0) e_busy--;
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic mode(input logic [1:0] b, input logic [11:0] ad, input string req);
    apply(1, 0, 0, 0, 0, b, ad, 1, req);
  endtask

  task automatic nop(input string req);
    apply(1, 1, 1, 1, 1, 2'b00, 12'h000, 1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    nop("R9");

    // R2 R3: every burst, ordering and latency code
    for (int bt = 0; bt < 2; bt++)
      for (int cl = 0; cl < 8; cl++)
        for (int bl = 0; bl < 8; bl++) begin
          mode(2'b00, 12'((cl << 4) | (bt << 3) | bl), "R2");
          nop("R2");
        end

    // R5 R10: every DLL and driver combination, main fields stay
    do_reset();
    mode(2'b00, 12'h04A, "R2");  // lat 4, interleaved, burst 4
    nop("R10");
    for (int d = 0; d < 4; d++)
      for (int off = 0; off < 2; off++) begin
        mode(2'b01, 12'(((d >> 1) << 6) | ((d & 1) << 1) | off), "R5");
        nop("R10");
      end
    // R10: main write keeps extended fields
    mode(2'b00, 12'h053, "R10");
    nop("R10");

    // R6: each extended reserved bit alone
    for (int bit_i = 2; bit_i < 12; bit_i++) begin
      if (bit_i == 6) continue;
      do_reset();
      mode(2'b01, 12'h002, "R5");
      nop("R6");
      mode(2'b01, 12'((1 << bit_i) | 12'h001), "R6");
      nop("R6");
    end
    do_reset();
    mode(2'b11, 12'h000, "R6");
    nop("R6");

    // R3: each main reserved bit alone, and bank bit 1
    for (int bit_i = 7; bit_i < 12; bit_i++) begin
      if (bit_i == 8) continue;
      do_reset();
      mode(2'b00, 12'(12'h032 | (1 << bit_i)), "R3");
      nop("R3");
    end
    do_reset();
    mode(2'b10, 12'h032, "R3");
    nop("R3");

    // R4: DLL reset pulse with field update
    do_reset();
    mode(2'b00, 12'h153, "R4");
    nop("R4");
    nop("R4");

    // R1: clock enable low, and each strobe high, do nothing
    do_reset();
    apply(0, 0, 0, 0, 0, 2'b00, 12'h053, 1, "R1");
    apply(1, 1, 0, 0, 0, 2'b00, 12'h053, 1, "R1");
    apply(1, 0, 1, 0, 0, 2'b00, 12'h053, 1, "R1");
    apply(1, 0, 0, 1, 0, 2'b00, 12'h053, 1, "R1");
    apply(1, 0, 0, 0, 1, 2'b00, 12'h053, 1, "R1");

    // R7: banks open
    do_reset();
    apply(1, 0, 0, 0, 0, 2'b00, 12'h053, 0, "R7");
    mode(2'b00, 12'h042, "R7");   // no window was opened, so this lands

    // R8: mode command inside the window is dropped
    do_reset();
    mode(2'b00, 12'h053, "R8");
    mode(2'b00, 12'h032, "R8");
    nop("R8");
    // R8: other command inside the window
    do_reset();
    mode(2'b01, 12'h000, "R8");
    apply(1, 0, 0, 1, 1, 2'b00, 12'h000, 1, "R8");
    nop("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule